// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software by counting down from a programmable timeout on each pulse of a slow clock-enable tick. Software must reload it with a two-step feed before the count runs out. If the count runs out, the block raises a chip reset request. In windowed mode, a feed that arrives while the count is still above a programmed window value is also a fault. A feed sequence that is broken is a fault as well.

A warning interrupt is set when the count reaches a programmed compare value, so software gets notice before expiry. Once software sets the enable, software cannot clear it. Only a system reset or a watchdog fault clears it.

A sticky flag records that the watchdog caused the last reset. This flag survives the system reset and is cleared only by power-on reset or by a software write. A new timeout value written by software is held aside and goes into the counter at the next valid feed.

Top module: `wdog_win`

## Requirements
- R1: After power-on reset, `rst_req_o`, `warn_irq_o`, `enabled_o` and `timeout_flag_o` are low, and `count_o` equals the parameter `TMO_RST`.
- R2: Writing 1 to bit 0 of the control register (address 0) sets the enable. Writing 0 to that bit afterwards leaves `enabled_o` high, and counting goes on.
- R3: While enabled, each cycle with `tick_i` high lowers `count_o` by one, and the count does not go below 0. Without a tick, or while disabled, `count_o` holds.
- R4: A tick while enabled at a count of 0 raises `rst_req_o` on the next clock edge and clears `enabled_o`. `rst_req_o` then stays high until `rst_ni` or `por_ni` is asserted.
- R5: A valid feed loads the counter on the clock edge that takes the second key. A valid feed is a `feed_i` strobe with key 0xAA, followed later by a strobe with key 0x55, with no register write in between.
- R6: A write to the timeout register (address 1) leaves `count_o` unchanged. The written value is loaded at the next valid feed.
- R7: While enabled, a fault is raised when, after a 0xAA key, the next event is either a key other than 0x55 or any register write. The fault raises `rst_req_o` the same way as an expiry.
- R8: A feed strobe whose key is not 0xAA, with no sequence started, is ignored: the count is unchanged and no fault is raised.
- R9: With bit 1 of the control register set (windowed mode), a valid feed while `count_o` is greater than the window register (address 2) is a fault and does not reload. A valid feed at a count less than or equal to the window register reloads normally.
- R10: While enabled, `warn_irq_o` is set on the clock edge after `count_o` equals the warning compare register (address 3). It stays set until a control write with bit 2 set clears it.
- R11: `timeout_flag_o` is set by every fault and is not cleared by `rst_ni`. It is cleared only by `por_ni`, or by a control write with bit 3 set.
- R12: While disabled, no fault is raised: the count does not expire, and a broken feed sequence is not a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async system reset (includes watchdog-caused reset) |
| por_ni | input | 1 | Active-low async power-on reset, also clears the sticky flag |
| tick_i | input | 1 | Count-enable tick from the watchdog clock domain |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 timeout, 2 window, 3 warning compare |
| wr_data_i | input | CNT_W | Register write data |
| feed_i | input | 1 | Feed key strobe |
| feed_key_i | input | 8 | Feed key value |
| rst_req_o | output | 1 | Chip reset request, held until reset |
| warn_irq_o | output | 1 | Early-warning interrupt, sticky |
| enabled_o | output | 1 | Watchdog enable status |
| timeout_flag_o | output | 1 | Sticky flag: the watchdog caused a fault |
| count_o | output | CNT_W | Current counter value |

## Verification
A corrupted count shows on `count_o` on the first tick after the corruption. Because the counter steps once per tick, a missed or doubled step is seen at the next tick. A feed-state machine stuck in the armed state shows on `rst_req_o`: the next register write raises it. A window comparison with the wrong sense either reloads at a count above the window or raises `rst_req_o` at a count on the window. Both show on the edge that takes the 0x55 key. A sticky flag tied to the wrong reset shows as `timeout_flag_o` low right after a system-only reset that follows an expiry.

// File: rtl/wdog_win_pkg.sv
package wdog_win_pkg;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_ARM  = 8'hAA;
  localparam logic [KEY_W-1:0] KEY_FIRE = 8'h55;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_TMO  = 2'd1,
    REG_WIN  = 2'd2,
    REG_WARN = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_WIN  = 1;
  localparam int CTRL_WCLR = 2;
  localparam int CTRL_FCLR = 3;

  typedef enum logic {FEED_IDLE, FEED_ARMED} feed_st_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_win_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] TMO_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             fault_i,
  output logic             en_o,
  output logic             win_en_o,
  output logic [CNT_W-1:0] tmo_o,
  output logic [CNT_W-1:0] win_o,
  output logic [CNT_W-1:0] warn_cmp_o,
  output logic             warn_clr_o,
  output logic             flag_clr_o
);
  logic wr_ctrl;
  assign wr_ctrl    = wr_en_i && (reg_addr_e'(wr_addr_i) == REG_CTRL);
  assign warn_clr_o = wr_ctrl && wr_data_i[CTRL_WCLR];
  assign flag_clr_o = wr_ctrl && wr_data_i[CTRL_FCLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      win_en_o   <= 1'b0;
      tmo_o      <= TMO_RST;
      win_o      <= '1;
      warn_cmp_o <= '0;
    end else begin
      // enable is set-only from software; a fault clears it
      if (fault_i)                           en_o <= 1'b0;
      else if (wr_ctrl && wr_data_i[CTRL_EN]) en_o <= 1'b1;
      if (wr_ctrl) win_en_o <= wr_data_i[CTRL_WIN];
      if (wr_en_i) begin
        unique case (reg_addr_e'(wr_addr_i))
          REG_TMO:  tmo_o      <= wr_data_i;
          REG_WIN:  win_o      <= wr_data_i;
          REG_WARN: warn_cmp_o <= wr_data_i;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wdog_feed.sv
module wdog_feed
  import wdog_win_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             feed_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             reg_wr_i,
  output logic             ok_o,
  output logic             err_o
);
  feed_st_e st_q, st_d;
  logic armed;

  assign armed = (st_q == FEED_ARMED);
  assign ok_o  = armed && feed_i && (key_i == KEY_FIRE) && !reg_wr_i;
  assign err_o = armed && ((feed_i && (key_i != KEY_FIRE)) || reg_wr_i);

  always_comb begin
    st_d = st_q;
    if (armed) begin
      if (ok_o || err_o) st_d = FEED_IDLE;
    end else if (feed_i && (key_i == KEY_ARM)) begin
      st_d = FEED_ARMED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= FEED_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] warn_cmp_i,
  input  logic [CNT_W-1:0] win_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             warn_hit_o,
  output logic             above_win_o
);
  logic at_zero;
  assign at_zero     = (cnt_o == '0);
  assign expire_o    = run_i && tick_i && at_zero;
  assign warn_hit_o  = run_i && (cnt_o == warn_cmp_i);
  assign above_win_o = (cnt_o > win_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_o <= RST_VAL;
    else if (load_i)                      cnt_o <= load_val_i;
    else if (run_i && tick_i && !at_zero) cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/wdog_win.sv
module wdog_win
  import wdog_win_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] TMO_RST = 16'h00FF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             feed_i,
  input  logic [7:0]       feed_key_i,
  output logic             rst_req_o,
  output logic             warn_irq_o,
  output logic             enabled_o,
  output logic             timeout_flag_o,
  output logic [CNT_W-1:0] count_o
);
  logic             core_rst_n;
  logic             en, win_en, warn_clr, flag_clr;
  logic [CNT_W-1:0] tmo, win, warn_cmp;
  logic             feed_ok, seq_err;
  logic             expire, warn_hit, above_win;
  logic             early, fault;

  assign core_rst_n = rst_ni & por_ni;

  wdog_regs #(.CNT_W(CNT_W), .TMO_RST(TMO_RST)) regs_i (
    .clk_i, .rst_ni(core_rst_n), .wr_en_i, .wr_addr_i, .wr_data_i,
    .fault_i(fault), .en_o(en), .win_en_o(win_en), .tmo_o(tmo),
    .win_o(win), .warn_cmp_o(warn_cmp), .warn_clr_o(warn_clr),
    .flag_clr_o(flag_clr)
  );

  wdog_feed feed_i_u (
    .clk_i, .rst_ni(core_rst_n), .feed_i, .key_i(feed_key_i),
    .reg_wr_i(wr_en_i), .ok_o(feed_ok), .err_o(seq_err)
  );

  wdog_counter #(.CNT_W(CNT_W), .RST_VAL(TMO_RST)) cnt_i (
    .clk_i, .rst_ni(core_rst_n), .run_i(en), .tick_i,
    .load_i(feed_ok && !fault), .load_val_i(tmo), .warn_cmp_i(warn_cmp),
    .win_i(win), .cnt_o(count_o), .expire_o(expire),
    .warn_hit_o(warn_hit), .above_win_o(above_win)
  );

  assign early = feed_ok && win_en && above_win;
  assign fault = en && (expire || seq_err || early);

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rst_req_o  <= 1'b0;
      warn_irq_o <= 1'b0;
    end else begin
      if (fault) rst_req_o <= 1'b1;
      if (warn_hit)      warn_irq_o <= 1'b1;
      else if (warn_clr) warn_irq_o <= 1'b0;
    end
  end

  // survives system reset; only power-on clears it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)       timeout_flag_o <= 1'b0;
    else if (fault)    timeout_flag_o <= 1'b1;
    else if (flag_clr) timeout_flag_o <= 1'b0;
  end

  assign enabled_o = en;
endmodule

// File: rtl/wdog_win_chk.sv
module wdog_win_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ni,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             feed_i,
  input logic             rst_req_o,
  input logic             warn_irq_o,
  input logic             enabled_o,
  input logic             timeout_flag_o,
  input logic [CNT_W-1:0] count_o
);
  assert_enable_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    enabled_o |=> (enabled_o || rst_req_o));

  assert_hold_no_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (!tick_i && !feed_i) |=> $stable(count_o));

  assert_step_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (enabled_o && tick_i && !feed_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));

  assert_expiry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (enabled_o && tick_i && count_o == '0) |=> (rst_req_o && !enabled_o));

  assert_req_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    rst_req_o |=> rst_req_o);

  assert_warn_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (warn_irq_o && !(wr_en_i && wr_addr_i == 2'd0 && wr_data_i[2])) |=> warn_irq_o);

  assert_flag_on_fault_R11: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(rst_req_o) |-> timeout_flag_o);

  assert_quiet_when_off_R12: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (!enabled_o && !rst_req_o) |=> !rst_req_o);
endmodule

bind wdog_win wdog_win_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni), .tick_i(tick_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .feed_i(feed_i), .rst_req_o(rst_req_o), .warn_irq_o(warn_irq_o),
  .enabled_o(enabled_o), .timeout_flag_o(timeout_flag_o), .count_o(count_o)
);

// File: tb/wdog_win_tb.sv
module wdog_win_tb_top;
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] TMO_RST = 16'h00FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, feed = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [7:0] feed_key = '0;
  logic rst_req, warn_irq, enabled, tflag;
  logic [CNT_W-1:0] count;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_win #(.CNT_W(CNT_W), .TMO_RST(TMO_RST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .feed_i(feed), .feed_key_i(feed_key), .rst_req_o(rst_req),
    .warn_irq_o(warn_irq), .enabled_o(enabled), .timeout_flag_o(tflag),
    .count_o(count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit por);
    @(negedge clk);
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_feed(input logic [7:0] k);
    @(negedge clk);
    feed = 1'b1; feed_key = k;
    @(negedge clk);
    feed = 1'b0;
  endtask

  task automatic do_tick(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 warn", warn_irq, 0);
    chk("R1 enabled", enabled, 0);
    chk("R1 flag", tflag, 0);
    chk("R1 count", count, TMO_RST);
  endtask

  task automatic t_disabled;
    do_tick(5);
    chk("R3/R12 count holds while disabled", count, TMO_RST);
    do_feed(8'h33);
    chk("R8 stray key count", count, TMO_RST);
    chk("R8 stray key no fault", rst_req, 0);
    do_feed(8'hAA);
    do_wr(2'd2, 16'hFFFF);
    chk("R12 broken sequence disabled", rst_req, 0);
    chk("R12 flag untouched", tflag, 0);
  endtask

  task automatic t_count_feed;
    do_wr(2'd1, 16'd20);
    chk("R6 timeout write keeps count", count, TMO_RST);
    do_wr(2'd0, 16'h0001);
    chk("R2 enabled", enabled, 1);
    do_tick(5);
    chk("R3 count after 5 ticks", count, TMO_RST - 5);
    do_wr(2'd0, 16'h0000);
    chk("R2 enable not cleared", enabled, 1);
    do_feed(8'hAA);
    chk("R5 no load after first key", count, TMO_RST - 5);
    do_feed(8'h55);
    chk("R5 reload to new timeout", count, 20);
    do_wr(2'd1, 16'd30);
    do_tick(3);
    chk("R6 old count still running", count, 17);
    do_feed(8'hAA);
    do_feed(8'h55);
    chk("R6 new timeout at feed", count, 30);
  endtask

  task automatic t_expire;
    do_tick(30);
    chk("R3 count at zero", count, 0);
    chk("R4 no request yet", rst_req, 0);
    do_tick(1);
    chk("R4 request on expiry", rst_req, 1);
    chk("R4 enable cleared", enabled, 0);
    chk("R11 flag set", tflag, 1);
    repeat (3) @(negedge clk);
    chk("R4 request held", rst_req, 1);
    do_reset(0);
    chk("R4 request cleared by reset", rst_req, 0);
    chk("R11 flag survives system reset", tflag, 1);
    do_wr(2'd0, 16'h0008);
    chk("R11 flag cleared by write", tflag, 0);
    do_reset(1);
  endtask

  task automatic t_seq_err;
    do_wr(2'd0, 16'h0001);
    do_feed(8'hAA);
    do_feed(8'h12);
    chk("R7 wrong second key", rst_req, 1);
    chk("R11 flag on sequence fault", tflag, 1);
    do_reset(0);
    do_wr(2'd0, 16'h0001);
    do_feed(8'hAA);
    do_wr(2'd3, 16'h0000);
    chk("R7 write between keys", rst_req, 1);
    do_reset(1);
  endtask

  task automatic t_window;
    do_wr(2'd1, 16'd40);
    do_wr(2'd2, 16'd10);
    do_wr(2'd0, 16'h0003);
    do_tick(TMO_RST - 10);
    chk("R3 count at window", count, 10);
    do_feed(8'hAA);
    do_feed(8'h55);
    chk("R9 feed at window reloads", count, 40);
    chk("R9 feed at window no fault", rst_req, 0);
    do_tick(5);
    do_feed(8'hAA);
    do_feed(8'h55);
    chk("R9 early feed fault", rst_req, 1);
    chk("R9 early feed no reload", count, 35);
    do_reset(1);
  endtask

  task automatic t_warn;
    do_wr(2'd3, 16'd5);
    do_wr(2'd0, 16'h0001);
    do_tick(TMO_RST - 5);
    chk("R10 count at compare", count, 5);
    chk("R10 warn not yet", warn_irq, 0);
    @(negedge clk);
    chk("R10 warn set", warn_irq, 1);
    do_tick(2);
    chk("R10 warn held", warn_irq, 1);
    chk("R3 count past compare", count, 3);
    do_wr(2'd0, 16'h0005);
    chk("R10 warn cleared", warn_irq, 0);
    chk("R2 still enabled", enabled, 1);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_count_feed();
    t_expire();
    t_seq_err();
    t_window();
    t_warn();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule